// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache

This block sits between an instruction fetch port and a memory port that returns one 32-bit word per acknowledged request. It holds 1 KB of code: two ways of 32 sets each, and four words in every line. A fetch that hits returns its word in the same cycle. A fetch that misses refills the whole line from memory, starting at word 0. The requested word is handed to the fetch port in the cycle that memory delivers it, and the fill then completes.

A lock input pins lines in place. Any line allocated while `lock_mode` is high is marked locked and is never chosen as a victim. If both ways of a set are locked, a miss in that set is served as a single uncached memory read. The `inval` input clears every unlocked line. The `en` input turns all fetches into uncached single reads and leaves the stored contents as they are.

A three-state controller governs the block. The states are ST_IDLE (lookup), ST_FILL (line refill) and ST_BYPASS (single uncached read). The transitions are:
- ST_IDLE to ST_FILL on an enabled miss that has a replaceable way.
- ST_IDLE to ST_BYPASS on a fetch while disabled, or on an enabled miss when both ways of the set are locked.
- ST_FILL to ST_IDLE on the acknowledge of word 3.
- ST_BYPASS to ST_IDLE on the acknowledge of its single read.

Top module: `lock_icache`

## Requirements
- R1: During and after reset, with no fetch pending, `ready` and `mem_req` are low, and every line is invalid, so the first fetch of any address misses.
- R2: A fetch to a valid line whose tag matches, with `en` high and `inval` low, raises `ready` in the same cycle with the stored word on `rdata` and no memory request.
- R3: A refill requests the line's words in the order offset 0, 1, 2, 3 on `mem_addr` = {tag, set, offset}. Each address is held until `mem_ack`, and `rdata` always equals the memory word at the fetched address.
- R4: During a refill, `ready` rises in the cycle the word at the fetched address is acknowledged: a miss at offset k completes with the (k+1)-th memory read. Further fetches wait until the line is complete.
- R5: A word address is split with bits [1:0] as the word offset, bits [6:2] as the set and the upper bits as the tag. Two different tags may reside in one set at the same time.
- R6: The victim is chosen in this order: an invalid unlocked way (way 0 first), otherwise the other way if one way is locked, otherwise the least recently used way. Hits and fills both update the recency of their set.
- R7: A line allocated while `lock_mode` is high is locked, and no later miss replaces it.
- R8: When both ways of a set are locked, a miss in that set makes exactly one memory read, returns that word and allocates nothing, so a repeat of the same fetch again reads memory.
- R9: `inval` high during an idle cycle invalidates all unlocked lines. Locked lines keep hitting.
- R10: With `en` low, every fetch makes exactly one memory read, and the stored lines are unchanged: after `en` returns high, lines cached before still hit, and addresses read while disabled still miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Cache enable; low makes every fetch uncached |
| inval | input | 1 | Invalidate all unlocked lines (acted on in idle cycles) |
| lock_mode | input | 1 | Lines allocated while high become locked |
| req | input | 1 | Fetch request, held until `ready` |
| addr | input | AW | Fetch word address |
| ready | output | 1 | Fetch word valid on `rdata` this cycle |
| rdata | output | DW | Fetched instruction word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory read acknowledge |

## Verification
The bench tries the lookup with four kinds of fetch pattern:
- A sweep that fills both ways of all 32 sets with offsets that rotate by set, then reads back every word of all 64 lines. This separates set decoding, tag compare and critical-word timing.
- Alternating tags within one set. These separate LRU victim choice from a fixed-way policy.
- Repeated misses in a set with one or both ways locked. These show whether lock bits steer or suppress allocation.
- Fetches around invalidate and disable, with the memory read count compared arithmetically each time. These tell which lines survived and whether anything was allocated.

// File: rtl/icache_pkg.sv
package icache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_BYPASS = 2'd2
    } ic_state_e;
endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
    parameter int SETS  = 32,
    parameter int TAG_W = 9,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [1:0]       hit_vec,
    output logic             victim_way,
    output logic             no_victim,
    input  logic             alloc,
    input  logic             al_way,
    input  logic             al_lock,
    input  logic             commit,
    input  logic [IDX_W-1:0] cm_idx,
    input  logic             cm_way,
    input  logic             touch,
    input  logic             t_way,
    input  logic             inval_do,
    output logic [2*SETS-1:0] vld_flat,
    output logic [2*SETS-1:0] lck_flat
);
    logic [TAG_W-1:0] tag_q [2][SETS];
    logic [SETS-1:0]  vld_q [2];
    logic [SETS-1:0]  lck_q [2];
    logic [SETS-1:0]  lru_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign hit_vec[w] = vld_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);
    end

    assign vld_flat = {vld_q[1], vld_q[0]};
    assign lck_flat = {lck_q[1], lck_q[0]};

    logic free0, free1;
    assign free0 = ~lck_q[0][lk_idx];
    assign free1 = ~lck_q[1][lk_idx];

    always_comb begin
        no_victim  = 1'b0;
        victim_way = 1'b0;
        if (!free0 && !free1)           no_victim  = 1'b1;
        else if (free0 && !vld_q[0][lk_idx]) victim_way = 1'b0;
        else if (free1 && !vld_q[1][lk_idx]) victim_way = 1'b1;
        else if (!free0)                victim_way = 1'b1;
        else if (!free1)                victim_way = 1'b0;
        else                            victim_way = lru_q[lk_idx];
    end

    always_ff @(posedge clk) begin
        if (alloc) tag_q[al_way][lk_idx] <= lk_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= '0;
            vld_q[1] <= '0;
            lck_q[0] <= '0;
            lck_q[1] <= '0;
            lru_q    <= '0;
        end else begin
            if (inval_do) begin
                vld_q[0] <= vld_q[0] & lck_q[0];
                vld_q[1] <= vld_q[1] & lck_q[1];
            end
            if (alloc) begin
                vld_q[al_way][lk_idx] <= 1'b0;
                lck_q[al_way][lk_idx] <= al_lock;
                lru_q[lk_idx]         <= ~al_way;
            end
            if (commit) vld_q[cm_way][cm_idx] <= 1'b1;
            if (touch)  lru_q[lk_idx]         <= ~t_way;
        end
    end
endmodule

// File: rtl/icache_data.sv
module icache_data #(
    parameter int SETS  = 32,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS),
    localparam int DEPTH = SETS * WORDS
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_way,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_way,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [OFF_W-1:0] rd_off,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] arr_q [2][DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) arr_q[wr_way][{wr_idx, wr_off}] <= wr_data;
    end

    assign rd_data = arr_q[rd_way][{rd_idx, rd_off}];
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int AW    = 16,
    parameter int SETS  = 32,
    parameter int WORDS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS),
    localparam int TAG_W = AW - IDX_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [AW-1:0]    addr,
    input  logic             en,
    input  logic             inval,
    input  logic [1:0]       hit_vec,
    input  logic             victim_way,
    input  logic             no_victim,
    input  logic             mem_ack,
    output ic_state_e        state,
    output logic             ready,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             sel_mem,
    output logic             alloc,
    output logic             commit,
    output logic             touch,
    output logic             inval_do,
    output logic             wr_en,
    output logic [OFF_W-1:0] wr_off,
    output logic [IDX_W-1:0] ctx_idx,
    output logic             ctx_way
);
    ic_state_e state_q, state_d;

    logic [TAG_W-1:0] ctx_tag_q;
    logic [IDX_W-1:0] ctx_idx_q;
    logic [OFF_W-1:0] ctx_off_q, cnt_q;
    logic             ctx_way_q;

    logic [TAG_W-1:0] a_tag;
    logic [IDX_W-1:0] a_idx;
    logic [OFF_W-1:0] a_off;
    assign a_off = addr[OFF_W-1:0];
    assign a_idx = addr[OFF_W +: IDX_W];
    assign a_tag = addr[AW-1 -: TAG_W];

    logic lookup, hit, last;
    logic [AW-1:0] fill_addr, byp_addr;
    assign lookup    = req & en & ~inval;
    assign hit       = |hit_vec;
    assign last      = (cnt_q == OFF_W'(WORDS - 1));
    assign fill_addr = {ctx_tag_q, ctx_idx_q, cnt_q};
    assign byp_addr  = {ctx_tag_q, ctx_idx_q, ctx_off_q};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req && !en)          state_d = ST_BYPASS;
                else if (lookup && !hit) state_d = no_victim ? ST_BYPASS : ST_FILL;
            end
            ST_FILL:   if (mem_ack && last) state_d = ST_IDLE;
            ST_BYPASS: if (mem_ack)         state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // miss context and refill counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_tag_q <= '0;
            ctx_idx_q <= '0;
            ctx_off_q <= '0;
            ctx_way_q <= 1'b0;
            cnt_q     <= '0;
        end else if (state_q == ST_IDLE && state_d != ST_IDLE) begin
            ctx_tag_q <= a_tag;
            ctx_idx_q <= a_idx;
            ctx_off_q <= a_off;
            ctx_way_q <= victim_way;
            cnt_q     <= '0;
        end else if (state_q == ST_FILL && mem_ack) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ready    = 1'b0;
        mem_req  = 1'b0;
        mem_addr = '0;
        sel_mem  = 1'b0;
        alloc    = 1'b0;
        commit   = 1'b0;
        touch    = 1'b0;
        inval_do = 1'b0;
        wr_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready    = lookup & hit;
                touch    = lookup & hit;
                alloc    = lookup & ~hit & ~no_victim;
                inval_do = inval;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = fill_addr;
                sel_mem  = 1'b1;
                wr_en    = mem_ack;
                commit   = mem_ack & last;
                ready    = req & mem_ack & (addr == fill_addr);
            end
            ST_BYPASS: begin
                mem_req  = 1'b1;
                mem_addr = byp_addr;
                sel_mem  = 1'b1;
                ready    = req & mem_ack & (addr == byp_addr);
            end
            default: ;
        endcase
    end

    assign state   = state_q;
    assign wr_off  = cnt_q;
    assign ctx_idx = ctx_idx_q;
    assign ctx_way = ctx_way_q;
endmodule

// File: rtl/lock_icache.sv
module lock_icache
    import icache_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int SETS  = 32,
    parameter int WORDS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int OFF_W = $clog2(WORDS),
    localparam int TAG_W = AW - IDX_W - OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          inval,
    input  logic          lock_mode,
    input  logic          req,
    input  logic [AW-1:0] addr,
    output logic          ready,
    output logic [DW-1:0] rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);
    ic_state_e        st;
    logic [1:0]       hit_vec;
    logic             victim_way, no_victim;
    logic             sel_mem, alloc, commit, touch, inval_do, wr_en;
    logic [OFF_W-1:0] wr_off;
    logic [IDX_W-1:0] ctx_idx;
    logic             ctx_way;
    logic [DW-1:0]    arr_rdata;
    logic [2*SETS-1:0] vld_flat, lck_flat;

    logic [IDX_W-1:0] a_idx;
    logic [TAG_W-1:0] a_tag;
    logic [OFF_W-1:0] a_off;
    assign a_off = addr[OFF_W-1:0];
    assign a_idx = addr[OFF_W +: IDX_W];
    assign a_tag = addr[AW-1 -: TAG_W];

    icache_ctrl #(.AW(AW), .SETS(SETS), .WORDS(WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .en(en), .inval(inval),
        .hit_vec(hit_vec), .victim_way(victim_way), .no_victim(no_victim),
        .mem_ack(mem_ack), .state(st), .ready(ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .sel_mem(sel_mem), .alloc(alloc), .commit(commit),
        .touch(touch), .inval_do(inval_do), .wr_en(wr_en), .wr_off(wr_off),
        .ctx_idx(ctx_idx), .ctx_way(ctx_way)
    );

    icache_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .lk_idx(a_idx), .lk_tag(a_tag),
        .hit_vec(hit_vec), .victim_way(victim_way), .no_victim(no_victim),
        .alloc(alloc), .al_way(victim_way), .al_lock(lock_mode),
        .commit(commit), .cm_idx(ctx_idx), .cm_way(ctx_way),
        .touch(touch), .t_way(hit_vec[1]), .inval_do(inval_do),
        .vld_flat(vld_flat), .lck_flat(lck_flat)
    );

    icache_data #(.SETS(SETS), .WORDS(WORDS), .DW(DW)) u_data (
        .clk(clk), .wr_en(wr_en), .wr_way(ctx_way), .wr_idx(ctx_idx),
        .wr_off(wr_off), .wr_data(mem_rdata), .rd_way(hit_vec[1]),
        .rd_idx(a_idx), .rd_off(a_off), .rd_data(arr_rdata)
    );

    assign rdata = sel_mem ? mem_rdata : arr_rdata;
endmodule

// File: rtl/lock_icache_chk.sv
module lock_icache_chk
    import icache_pkg::*;
#(
    parameter int AW   = 16,
    parameter int SETS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input ic_state_e         state,
    input logic              ready,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [AW-1:0]     mem_addr,
    input logic [1:0]        hit_vec,
    input logic [2*SETS-1:0] vld_flat,
    input logic [2*SETS-1:0] lck_flat
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mem_req);

    // R3
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_ack && mem_addr[1:0] != 2'd3)
        |=> (state == ST_FILL && mem_addr[1:0] == $past(mem_addr[1:0]) + 2'd1));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    // R4
    mem_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && ready) |-> mem_ack);

    // R5
    single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R7
    locked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(vld_flat & lck_flat) & ~(vld_flat & lck_flat)) == '0));
endmodule

bind lock_icache lock_icache_chk #(.AW(AW), .SETS(SETS)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(st), .ready(ready), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .hit_vec(hit_vec),
    .vld_flat(vld_flat), .lck_flat(lck_flat)
);

// File: tb/lock_icache_test.sv
module lock_icache_test;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, inval = 1'b0, lock_mode = 1'b0;
    logic req = 1'b0, mem_ack = 1'b0, ph = 1'b0;
    logic [AW-1:0] addr = '0;
    logic ready, mem_req;
    logic [DW-1:0] rdata, mem_rdata;
    logic [AW-1:0] mem_addr;
    int n_chk = 0, n_fail = 0, mem_cnt = 0;
    logic [AW-1:0] log_q [4];

    always #5 clk = ~clk;

    lock_icache uut (
        .clk(clk), .rst_n(rst_n), .en(en), .inval(inval), .lock_mode(lock_mode),
        .req(req), .addr(addr), .ready(ready), .rdata(rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    function automatic logic [AW-1:0] mk(input int t, input int s, input int o);
        return {t[8:0], s[4:0], o[1:0]};
    endfunction

    assign mem_rdata = memf(mem_addr);

    // memory model: acknowledge every second cycle of a request
    always @(negedge clk) begin
        if (!mem_req) begin
            ph      <= 1'b0;
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= ph;
            ph      <= ~ph;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            mem_cnt  <= mem_cnt + 1;
            log_q[3] <= mem_addr;
            log_q[2] <= log_q[3];
            log_q[1] <= log_q[2];
            log_q[0] <= log_q[1];
        end
    end

    task automatic chk_eq(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic settle();
        #4;
        while (mem_req) begin
            @(negedge clk);
            #4;
        end
        @(negedge clk);
    endtask

    // starts and ends at a falling edge
    task automatic tf(input string r, input logic [AW-1:0] a, input int exp_acc,
                      input bit do_settle);
        int start, waitc, acc;
        logic [DW-1:0] d;
        start = mem_cnt;
        waitc = 0;
        acc   = -1;
        d     = '0;
        req   = 1'b1;
        addr  = a;
        forever begin
            #4;
            if (ready) begin
                d   = rdata;
                acc = mem_cnt - start + (mem_ack ? 1 : 0);
                break;
            end
            @(negedge clk);
            waitc++;
            if (waitc > 300) break;
        end
        @(negedge clk);
        req = 1'b0;
        chk_eq({r, " data"}, d, memf(a));
        chk_eq({r, " memory reads"}, acc, exp_acc);
        if (do_settle) settle();
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #4;
        chk_eq("R1 ready in reset", ready, 0);
        chk_eq("R1 mem_req in reset", mem_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #4;
        chk_eq("R1 ready idle", ready, 0);
        chk_eq("R1 mem_req idle", mem_req, 0);
        @(negedge clk);

        // R1 R4: first fetch misses, critical word offset 2 is third read
        tf("R4 critical word", mk(1, 0, 2), 3, 1'b1);
        // R3: refill order
        for (int i = 0; i < 4; i++) chk_eq("R3 refill order", log_q[i], mk(1, 0, i));
        // R2: hits on all words of the line
        for (int w = 0; w < 4; w++) tf("R2 hit", mk(1, 0, w), 0, 1'b1);

        // R5 sweep: two tags per set, rotating offsets
        for (int s = 0; s < 32; s++) begin
            tf("R5 fill tag10", mk(10, s, s % 4), s % 4 + 1, 1'b1);
            tf("R5 fill tag11", mk(11, s, (s + 1) % 4), (s + 1) % 4 + 1, 1'b1);
        end
        for (int s = 0; s < 32; s++) begin
            for (int w = 0; w < 4; w++) tf("R5 R2 readback tag10", mk(10, s, w), 0, 1'b1);
            for (int w = 0; w < 4; w++) tf("R5 R2 readback tag11", mk(11, s, w), 0, 1'b1);
        end

        // R6: recency decides the victim in set 7
        tf("R6 touch tag10", mk(10, 7, 0), 0, 1'b1);
        tf("R6 new tag12", mk(12, 7, 0), 1, 1'b1);
        tf("R6 tag10 kept", mk(10, 7, 1), 0, 1'b1);
        tf("R6 tag11 evicted", mk(11, 7, 1), 2, 1'b1);
        tf("R6 tag10 still kept", mk(10, 7, 2), 0, 1'b1);
        tf("R6 tag12 evicted", mk(12, 7, 0), 1, 1'b1);

        // R7: lock a line in set 9 and churn the other way
        lock_mode = 1'b1;
        tf("R7 locked fill", mk(20, 9, 0), 1, 1'b1);
        lock_mode = 1'b0;
        tf("R7 churn 21", mk(21, 9, 0), 1, 1'b1);
        tf("R7 churn 22", mk(22, 9, 0), 1, 1'b1);
        tf("R7 churn 23", mk(23, 9, 1), 2, 1'b1);
        tf("R7 locked line resident", mk(20, 9, 3), 0, 1'b1);

        // R8: both ways locked gives uncached reads
        lock_mode = 1'b1;
        tf("R8 second locked fill", mk(24, 9, 0), 1, 1'b1);
        lock_mode = 1'b0;
        tf("R8 uncached read", mk(25, 9, 2), 1, 1'b1);
        tf("R8 not allocated", mk(25, 9, 2), 1, 1'b1);
        tf("R8 lock way0 hit", mk(20, 9, 1), 0, 1'b1);
        tf("R8 lock way1 hit", mk(24, 9, 2), 0, 1'b1);

        // R9: invalidate keeps only locked lines
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
        @(negedge clk);
        tf("R9 unlocked dropped", mk(10, 3, 0), 1, 1'b1);
        tf("R9 unlocked dropped", mk(11, 5, 1), 2, 1'b1);
        tf("R9 locked kept", mk(20, 9, 2), 0, 1'b1);
        tf("R9 locked kept", mk(24, 9, 3), 0, 1'b1);

        // R4: a fetch during a refill waits for its word
        tf("R4 first word", mk(40, 2, 0), 1, 1'b0);
        tf("R4 fetch during fill", mk(40, 2, 3), 3, 1'b1);
        tf("R4 line complete", mk(40, 2, 1), 0, 1'b1);

        // R10: disabled fetches read memory once and change nothing
        en = 1'b0;
        tf("R10 disabled cached addr", mk(10, 3, 1), 1, 1'b1);
        tf("R10 disabled new addr", mk(30, 4, 0), 1, 1'b1);
        en = 1'b1;
        tf("R10 old line still hits", mk(10, 3, 2), 0, 1'b1);
        tf("R10 nothing allocated", mk(30, 4, 0), 1, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule